// File: doc/BRIEF.md
# Processor Clock Divider and Reset Qualifier

This block sits between the board oscillator and the processor core. It halves the oscillator clock to form the processor clock. That clock feeds the core and is also driven on an output pin so that other system logic can run from it. The divider flop powers up at zero, so the phase of the processor clock is the same in every run.

The block also qualifies an active-low reset request. The request is asynchronous, so it first passes through a synchronizer. The synchronizer samples at the processor-clock rate and has two stages by default. A run counter then counts consecutive low samples. The reset is accepted only once the synchronized request has been low for three processor-clock cycles, so shorter dips are treated as noise and discarded. While the reset is accepted, the block drives two outputs: an active-low reset to the core and an active-high reset to peripherals. Both are released on a rising edge of the processor clock.

The whole block runs on the oscillator clock. Its state advances only on the oscillator edges where the processor clock rises, so every reset transition lines up with a rising processor-clock edge.

Top module: `cpu_clk_reset_gen`

## Requirements
- R1: `cpu_clk_o` changes level on every rising edge of `osc_clk_i`, so its period is two oscillator periods (oscillator frequency divided by two).
- R2: After power-up `cpu_clk_o` is 0 before the first oscillator edge and 1 after it. Both reset outputs start deasserted (`periph_rst_o` = 0, `core_rst_n_o` = 1).
- R3: The request is sampled on rising edges of `cpu_clk_o` and passes through two synchronizer stages before it is counted. Number the first rising edge that samples a low request as edge 1. The reset then asserts at edge 5, not earlier.
- R4: If the request is sampled low on three consecutive rising edges of `cpu_clk_o`, the reset is accepted: `periph_rst_o` goes to 1 and `core_rst_n_o` goes to 0.
- R5: A low request seen on only one or two consecutive samples never asserts the reset. A single high sample clears the run count, so two short low pulses separated by a high sample do not add up.
- R6: For as long as the request stays low after acceptance, the reset stays asserted, however many cycles that is. The run counter saturates at the threshold.
- R7: Let the first rising edge that samples the request high again be edge m. The reset releases at edge m+2. Edge m is counted in the same way as edge 1 of R3.
- R8: `core_rst_n_o` is always the complement of `periph_rst_o`.
- R9: The reset outputs change only on oscillator edges where `cpu_clk_o` rises. They never change on an edge where it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk_i | input | 1 | Oscillator clock, twice the processor clock rate |
| rst_req_n_i | input | 1 | Asynchronous reset request, active low |
| cpu_clk_o | output | 1 | Processor clock, oscillator divided by two |
| core_rst_n_o | output | 1 | Qualified reset to the core, active low |
| periph_rst_o | output | 1 | Qualified reset to peripherals, active high |

## Verification
The qualifier is driven with single low runs of 1, 2, 3, 4, 7 and 12 processor cycles. These lengths separate rejected glitches from the shortest accepted run. They also show how the number of cycles in reset grows with the length of the run. Two two-cycle dips split by one high sample show whether the run counter really clears rather than adding up. A 40-cycle hold exercises the saturated counter. Separate checks on the clock phase and period show whether the divider toggles on every oscillator edge from power-up. A monitor on falling processor-clock edges confirms that the resets only move on rising edges.

// File: rtl/ckrg_pkg.sv
package ckrg_pkg;

  // Width needed to hold a count from 0 up to and including lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Next value of the consecutive-low run counter. It saturates at lim,
  // and any high sample sends it back to zero.
  function automatic int unsigned low_run_next(input int unsigned cur,
                                               input logic        is_low,
                                               input int unsigned lim);
    if (!is_low)
      return 0;
    else if (cur >= lim)
      return lim;
    else
      return cur + 1;
  endfunction

  // True once the run has reached the acceptance threshold.
  function automatic logic run_accepted(input int unsigned run,
                                        input int unsigned lim);
    return run >= lim;
  endfunction

endpackage

// File: rtl/ckrg_div2.sv
module ckrg_div2 (
  input  logic osc_clk_i,
  output logic div_clk_o,
  output logic rise_tick_o
);

  // Power-up value fixes the phase of the divided clock.
  logic div_q   = 1'b0;
  logic armed_q = 1'b0;

  always_ff @(posedge osc_clk_i) begin
    div_q   <= ~div_q;
    armed_q <= 1'b1;
  end

  assign div_clk_o   = div_q;
  // High when the coming oscillator edge takes the divided clock 0 -> 1.
  assign rise_tick_o = ~div_q;

  // R1: the divided clock changes level on every oscillator edge.
  p_toggle_r1: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    div_q != $past(div_q));

endmodule

// File: rtl/ckrg_sync.sv
module ckrg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);

  // Every stage powers up at the idle (request released) level.
  logic [STAGES-1:0] stg_q = '1;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge osc_clk_i)
          if (en_i) stg_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge osc_clk_i)
          if (en_i) stg_q[gi] <= stg_q[gi-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

  initial begin
    if (STAGES < 2) $error("ckrg_sync needs at least two stages");
  end

endmodule

// File: rtl/ckrg_qual.sv
module ckrg_qual
  import ckrg_pkg::*;
#(
  parameter int unsigned MIN_LOW = 3
) (
  input  logic osc_clk_i,
  input  logic en_i,
  input  logic req_n_sync_i,
  output logic rst_o
);

  localparam int unsigned CNT_W = cnt_width(MIN_LOW);
  localparam logic [CNT_W-1:0] LIM      = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] LIM_LESS = CNT_W'(MIN_LOW - 1);

  logic [CNT_W-1:0] run_q   = '0;
  logic             rst_q   = 1'b0;
  logic             armed_q = 1'b0;
  logic [CNT_W-1:0] run_nxt;
  logic             sample_low;

  assign sample_low = ~req_n_sync_i;

  always_comb begin
    run_nxt = CNT_W'(low_run_next(32'(run_q), sample_low, MIN_LOW));
  end

  always_ff @(posedge osc_clk_i) begin
    armed_q <= 1'b1;
    if (en_i) begin
      run_q <= run_nxt;
      rst_q <= run_accepted(32'(run_nxt), MIN_LOW);
    end
  end

  assign rst_o = rst_q;

  // R6: the run counter never passes the threshold.
  p_run_sat_r6: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    run_q <= LIM);

  // R5: a high sample clears the run.
  p_run_clear_r5: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    (en_i && req_n_sync_i) |=> (run_q == '0));

  // R4: the third consecutive low sample accepts the reset.
  p_accept_r4: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    (en_i && !req_n_sync_i && run_q == LIM_LESS) |=> rst_q);

  // R6: the reset holds while the request stays low.
  p_hold_r6: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    (en_i && !req_n_sync_i && rst_q) |=> rst_q);

  // R7: a high synchronized sample releases the reset.
  p_release_r7: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    (en_i && req_n_sync_i) |=> !rst_q);

  // R9: nothing moves on oscillator edges where the divided clock falls.
  p_quiet_fall_r9: assert property (@(posedge osc_clk_i) disable iff (!armed_q)
    !en_i |=> $stable(rst_q));

endmodule

// File: rtl/cpu_clk_reset_gen.sv
module cpu_clk_reset_gen #(
  parameter int unsigned MIN_LOW_CYC = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic rst_req_n_i,
  output logic cpu_clk_o,
  output logic core_rst_n_o,
  output logic periph_rst_o
);

  logic rise_tick;
  logic req_n_sync;
  logic accepted;

  ckrg_div2 u_div (
    .osc_clk_i   (osc_clk_i),
    .div_clk_o   (cpu_clk_o),
    .rise_tick_o (rise_tick)
  );

  ckrg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .osc_clk_i (osc_clk_i),
    .en_i      (rise_tick),
    .d_i       (rst_req_n_i),
    .q_o       (req_n_sync)
  );

  ckrg_qual #(.MIN_LOW(MIN_LOW_CYC)) u_qual (
    .osc_clk_i    (osc_clk_i),
    .en_i         (rise_tick),
    .req_n_sync_i (req_n_sync),
    .rst_o        (accepted)
  );

  assign periph_rst_o = accepted;
  assign core_rst_n_o = ~accepted;

endmodule

// File: tb/cpu_clk_reset_gen_tb.sv
`timescale 1ns/1ps
module cpu_clk_reset_gen_tb;

  logic osc_clk = 1'b0;
  logic req_n   = 1'b1;
  logic cpu_clk, core_rst_n, periph_rst;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  bit mon_en   = 1'b0;

  always #2.5 osc_clk = ~osc_clk;   // 200 MHz

  cpu_clk_reset_gen u_dut (
    .osc_clk_i    (osc_clk),
    .rst_req_n_i  (req_n),
    .cpu_clk_o    (cpu_clk),
    .core_rst_n_o (core_rst_n),
    .periph_rst_o (periph_rst)
  );

  // Low-run lengths and the number of cycles in reset expected for each.
  localparam int NVEC = 6;
  localparam int VEC_LEN [NVEC] = '{1, 2, 3, 4, 7, 12};
  localparam int VEC_HI  [NVEC] = '{0, 0, 1, 2, 5, 10};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cpu_rise();
    @(posedge cpu_clk);
    #1;
  endtask

  // R9 monitor: on falling cpu edges the resets keep their previous value.
  logic last_rst = 1'b0;
  always @(posedge osc_clk) begin
    #1;
    if (mon_en && cpu_clk == 1'b0)
      chk("R9 reset moved on falling cpu edge", int'(periph_rst), int'(last_rst));
    last_rst = periph_rst;
  end

  // Runs one low pulse of len samples and checks every edge (R3 R4 R7 R8).
  task automatic low_run(input int len, output int hi_cycles);
    hi_cycles = 0;
    req_n = 1'b0;
    for (int j = 1; j <= len + 6; j++) begin
      bit exp_rst;
      cpu_rise();
      exp_rst = (len >= 3) && (j >= 5) && (j <= len + 2);
      if (j < 5)
        chk($sformatf("R3 latency len=%0d edge=%0d", len, j), int'(periph_rst), 0);
      else if (j <= len + 2)
        chk($sformatf("R4 accept len=%0d edge=%0d", len, j), int'(periph_rst), int'(exp_rst));
      else
        chk($sformatf("R7 release len=%0d edge=%0d", len, j), int'(periph_rst), 0);
      chk($sformatf("R8 complement len=%0d edge=%0d", len, j),
          int'(core_rst_n), int'(!periph_rst));
      if (periph_rst) hi_cycles++;
      if (j == len) req_n = 1'b1;
    end
  endtask

  initial begin
    int hi;
    int osc_cnt;
    #1;
    // R2: power-up state.
    chk("R2 cpu clk before first edge", int'(cpu_clk), 0);
    chk("R2 periph reset at power-up", int'(periph_rst), 0);
    chk("R2 core reset at power-up", int'(core_rst_n), 1);
    @(posedge osc_clk); #1;
    chk("R2 cpu clk after first edge", int'(cpu_clk), 1);

    // R1: level alternates on each oscillator edge, period two edges.
    for (int i = 0; i < 8; i++) begin
      logic prev;
      prev = cpu_clk;
      @(posedge osc_clk); #1;
      chk("R1 toggle per oscillator edge", int'(cpu_clk), int'(!prev));
    end
    cpu_rise();
    osc_cnt = 0;
    fork
      begin
        forever begin
          @(posedge osc_clk);
          osc_cnt++;
        end
      end
      begin
        @(posedge cpu_clk);
      end
    join_any
    disable fork;
    chk("R1 oscillator edges per cpu period", osc_cnt, 2);

    mon_en = 1'b1;
    for (int i = 0; i < 4; i++) cpu_rise();

    // Table walk: R4 accept, R5 reject, R3 latency, R7 release.
    for (int v = 0; v < NVEC; v++) begin
      low_run(VEC_LEN[v], hi);
      chk($sformatf("R4 R5 cycles in reset len=%0d", VEC_LEN[v]), hi, VEC_HI[v]);
      for (int i = 0; i < 3; i++) cpu_rise();
    end

    // R5: two short dips separated by one high sample must not combine.
    for (int j = 1; j <= 10; j++) begin
      req_n = !(j == 1 || j == 2 || j == 4 || j == 5);
      cpu_rise();
      chk($sformatf("R5 split dips edge=%0d", j), int'(periph_rst), 0);
    end
    req_n = 1'b1;
    for (int i = 0; i < 4; i++) cpu_rise();

    // R6: long hold stays in reset with a saturated counter.
    low_run(40, hi);
    chk("R6 long hold cycles in reset", hi, 38);
    for (int i = 0; i < 3; i++) cpu_rise();
    chk("R7 idle after long hold", int'(periph_rst), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule